// File: doc/BRIEF.md
# Multiples-of-Three-or-Five Summing Engine

This block walks the integers upward from 1, one per enabled clock cycle, and adds every value that is divisible by 3 or by 5 into a running total. It stops at a compile-time limit `LIMIT` and raises a done flag. Only values strictly below the limit are added. There is no divider anywhere in the datapath. Two short phase counters, of period three and of period five, advance in lockstep with the main counter. Each one reports when it sits on its top phase, and that marks the current value as a multiple of its period.

The block is used by releasing reset and holding `en` high until `done` rises. Then `total` is read. Dropping `en` pauses the whole engine without losing state. Pulsing reset starts a fresh pass.

Top module: `mult35_sum`

## Requirements
- R1: While `rst` is high at a clock edge, the engine returns to its start state: `total` = 0, `done` = 0, main count = 1, and both phase counters at phase 1.
- R2: With the default `LIMIT` = 1000 and `W` = 32, `total` equals 233168 once `done` is high.
- R3: A value divisible by both 3 and 5 is added only once. With `LIMIT` = 16, the final `total` is 60.
- R4: `done` goes high on the clock edge that takes the main count to `LIMIT`, which is the `LIMIT`-1-th enabled edge after reset. Before that edge `done` is 0.
- R5: Once `done` is high, `done` and `total` keep their values on every later edge until reset, whatever `en` does.
- R6: An edge with `en` low changes neither `total` nor the main count. A paused run ends with the same total, later by the number of paused edges.
- R7: The period-3 and period-5 phase counters flag a value only when it is a multiple of that period.
- R8: On an edge where the engine advances and a flag is set, `total` grows by exactly the current main count. Otherwise `total` is unchanged.
- R9: A reset in the middle of a run discards the partial sum. The following run produces the same result as one from power-up.
- R10: The parameter `W` sets the width of `total` and of all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the engine |
| total | output | W | Running and final sum of the multiples |
| done | output | 1 | High once every value below `LIMIT` has been visited |

## Verification
An uninterrupted run at `LIMIT` = 16 is checked at partial counts and at the final count. This separates correct single-counting of 15 from double-counting, and shows whether `done` arrives one edge early or one edge late. A run with a long stretch of `en` low in the middle tells a true freeze apart from counters that keep moving. Extra enabled edges after `done` expose a sum that keeps adding. At the default limit, a full run and a run restarted by a mid-way reset must both reach 233168. That separates a clean restart from a leftover partial sum or misaligned phase counters.

// File: rtl/m35_pkg.sv
package m35_pkg;

  // Next phase of a wrap-around counter that runs 1..period
  function automatic int unsigned phase_after(int unsigned p, int unsigned period);
    return (p >= period) ? 32'd1 : p + 32'd1;
  endfunction

  // A value is taken when any divisor flag is set
  function automatic logic any_hit(logic [1:0] flags);
    return |flags;
  endfunction

endpackage

// File: rtl/mod_ticker.sv
module mod_ticker #(
  parameter int unsigned PERIOD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic at_top
);
  import m35_pkg::*;

  localparam int unsigned PW = $clog2(PERIOD + 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)      phase <= PW'(1);
    else if (adv) phase <= PW'(phase_after(32'(phase), PERIOD));
  end

  assign at_top = (32'(phase) == PERIOD);

endmodule

// File: rtl/count_walker.sv
module count_walker #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] value,
  output logic         below
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst)      value <= W'(1);
    else if (adv) value <= value + W'(1);
  end

  assign below = (value < LIM);

endmodule

// File: rtl/sum_acc.sv
module sum_acc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         add_en,
  input  logic [W-1:0] addend,
  output logic [W-1:0] total
);
  always_ff @(posedge clk) begin
    if (rst)         total <= '0;
    else if (add_en) total <= total + addend;
  end
endmodule

// File: rtl/mult35_sum.sv
module mult35_sum #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] total,
  output logic         done
);
  import m35_pkg::*;

  localparam int unsigned NDIV = 2;
  localparam int unsigned PERIODS [NDIV] = '{3, 5};
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0]    count_val;
  logic            below;
  logic [NDIV-1:0] hit_vec;
  logic            adv;
  logic            add_en;
  logic            finish_now;

  // Named events used by the checker
  assign adv        = en & ~done & below;
  assign add_en     = adv & any_hit(hit_vec);
  assign finish_now = en & ~done & (~below | (count_val == LIM - W'(1)));

  for (genvar g = 0; g < NDIV; g++) begin : g_div
    mod_ticker #(.PERIOD(PERIODS[g])) u_tick (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv),
      .at_top (hit_vec[g])
    );
  end

  count_walker #(.LIMIT(LIMIT), .W(W)) u_walk (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .value (count_val),
    .below (below)
  );

  sum_acc #(.W(W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .add_en (add_en),
    .addend (count_val),
    .total  (total)
  );

  always_ff @(posedge clk) begin
    if (rst)             done <= 1'b0;
    else if (finish_now) done <= 1'b1;
  end

endmodule

// File: rtl/mult35_sum_chk.sv
module mult35_sum_chk #(
  parameter int unsigned LIMIT = 1000,
  parameter int unsigned W     = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         done,
  input logic [W-1:0] total,
  input logic [W-1:0] value,
  input logic         hit3,
  input logic         hit5,
  input logic         add_en
);

  // R5: completion is sticky
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R5: result held after completion
  a_r5_total_held: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(total));

  // R6: enable low freezes sum and count
  a_r6_pause_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(total) && $stable(value)));

  // R7: period-3 flag only on multiples of 3
  a_r7_hit3_mult: assert property (@(posedge clk) disable iff (rst)
    hit3 |-> (value % 3 == 0));

  // R7: period-5 flag only on multiples of 5
  a_r7_hit5_mult: assert property (@(posedge clk) disable iff (rst)
    hit5 |-> (value % 5 == 0));

  // R8: an accepted value is added exactly once
  a_r8_add_value: assert property (@(posedge clk) disable iff (rst)
    add_en |=> (total == $past(total) + $past(value)));

  // R8: no add means no change
  a_r8_no_add_hold: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> $stable(total));

  // R4: completion coincides with the count at the limit
  a_r4_done_at_limit: assert property (@(posedge clk) disable iff (rst)
    done |-> (value == W'(LIMIT) || LIMIT < 1));

endmodule

bind mult35_sum mult35_sum_chk #(.LIMIT(LIMIT), .W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en),
  .done   (done),
  .total  (total),
  .value  (count_val),
  .hit3   (hit_vec[0]),
  .hit5   (hit_vec[1]),
  .add_en (add_en)
);

// File: tb/test_mult35_sum.sv
module test_mult35_sum;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_a = 1'b1, en_a = 1'b0;
  logic rst_b = 1'b1, en_b = 1'b0;
  logic [W-1:0] total_a, total_b;
  logic done_a, done_b;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mult35_sum i_mult35_sum (
    .clk(clk), .rst(rst_a), .en(en_a), .total(total_a), .done(done_a));

  mult35_sum #(.LIMIT(16), .W(W)) i_mult35_sum_small (
    .clk(clk), .rst(rst_b), .en(en_b), .total(total_b), .done(done_b));

  // Reference: sum of multiples of 3 or 5 among 1..upto
  function automatic longint ref_sum(int upto);
    longint s = 0;
    for (int i = 1; i <= upto; i++)
      if ((i % 3 == 0) || (i % 5 == 0)) s += i;
    return s;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_both();
    @(negedge clk);
    rst_a = 1'b1; rst_b = 1'b1; en_a = 1'b0; en_b = 1'b0;
    @(negedge clk);
    rst_a = 1'b0; rst_b = 1'b0;
  endtask

  // exactly n enabled edges on the chosen instance, sampled at the negedge after
  task automatic run_a(int n);
    en_a = 1'b1;
    repeat (n) @(negedge clk);
    en_a = 1'b0;
  endtask

  task automatic run_b(int n);
    en_b = 1'b1;
    repeat (n) @(negedge clk);
    en_b = 1'b0;
  endtask

  task automatic t_reset_state();
    reset_both();
    check("R1 total_a", total_a, 0);
    check("R1 done_a", done_a, 0);
    check("R1 total_b", total_b, 0);
    check("R1 done_b", done_b, 0);
  endtask

  task automatic t_small_run();
    reset_both();
    run_b(5);
    check("R8 partial 5", total_b, ref_sum(5));
    run_b(9);
    check("R4 not done at 14", done_b, 0);
    check("R8 partial 14", total_b, ref_sum(14));
    run_b(1);
    check("R4 done at 15", done_b, 1);
    check("R3 total 16", total_b, 60);
  endtask

  task automatic t_hold();
    run_b(20);
    check("R5 done held", done_b, 1);
    check("R5 total held", total_b, 60);
    repeat (3) @(negedge clk);
    check("R5 held en low", total_b, 60);
  endtask

  task automatic t_pause();
    reset_both();
    run_b(7);
    check("R6 before pause", total_b, ref_sum(7));
    repeat (10) @(negedge clk);
    check("R6 paused total", total_b, ref_sum(7));
    check("R6 paused done", done_b, 0);
    run_b(7);
    check("R6 not done early", done_b, 0);
    check("R6 total at 14", total_b, ref_sum(14));
    run_b(1);
    check("R6 resumed done", done_b, 1);
    check("R6 resumed total", total_b, 60);
  endtask

  task automatic t_full();
    reset_both();
    run_a(998);
    check("R4 default not done", done_a, 0);
    check("R10 partial 998", total_a, ref_sum(998));
    run_a(1);
    check("R4 default done", done_a, 1);
    check("R2 default total", total_a, 233168);
  endtask

  task automatic t_midreset();
    reset_both();
    run_a(500);
    check("R9 partial 500", total_a, ref_sum(500));
    reset_both();
    check("R9 cleared", total_a, 0);
    run_a(999);
    check("R9 done", done_a, 1);
    check("R9 total", total_a, 233168);
  endtask

  initial begin
    t_reset_state();
    t_small_run();
    t_hold();
    t_pause();
    t_full();
    t_midreset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule